// File: doc/BRIEF.md
# Indirectly Addressed Vectored Interrupt Controller

This block collects up to 128 interrupt sources and drives a single interrupt request line toward a processor. Each source carries a small configuration (priority and trigger kind), a vector word, an enable bit and a pending bit. Software never sees these as wide bitmasks. It first writes a source number into a select register, and every following mode, vector or command access then applies to that one source only.

Among the sources that are both enabled and pending, a combinational arbiter picks the one with the highest priority, with ties going to the lowest source number. Reading the vector register returns the winner's vector and acknowledges it. The acknowledge pushes the winner's priority onto an 8-entry nesting stack, and from then on only strictly higher priorities can raise the request line. Each write to the end-of-interrupt register pops one level. When nothing is eligible, the vector read returns a programmable spurious value.

All register accesses use a simple single-cycle 32-bit bus. Read data is combinational from the address. Side effects of an access take effect at the clock edge that ends it.

Top module: `vic_indirect`

## Requirements
- R1: After reset every source is disabled and not pending, the stack is empty, irq is low, and the select, mask-status, status and spurious registers all read zero.
- R2: Offset 0x00 stores the low 7 bits of a write as the selected source and reads them back. Offset 0x04 holds the selected source's mode: priority in bits [2:0], and bit 4 set for rising-edge trigger or clear for active-high level. Offset 0x08 holds its vector. A write to 0x04 or 0x08 changes only the selected source.
- R3: Writing 0x40 or 0x44 with bit 0 set enables or disables the selected source only. With bit 0 clear the write does nothing. Offset 0x30 returns the enable bits of the 32-source bank numbered by select bits [6:5], with bit i standing for source bank*32+i.
- R4: An enabled level source requests while its input is high and stops when the input falls. A disabled source never drives irq.
- R5: An edge source latches pending on a rising input edge and stays pending after the input falls, until it is acknowledged.
- R6: Writing 0x4C with bit 0 set makes the selected source pending. Writing 0x48 with bit 0 set clears it.
- R7: A read of 0x10 while irq is high returns the vector of the highest-priority enabled pending source, with the lowest source number winning ties. Offset 0x18 then reads that source's number.
- R8: A successful vector read pushes the winner's priority. While the stack is non-empty, irq rises only for a priority strictly above the top entry.
- R9: A write to 0x38 pops the most recent nesting level, which lets lower priorities request again.
- R10: A read of 0x10 while irq is low returns the spurious register at 0x3C, pushes nothing, and leaves 0x18 reading zero.
- R11: The stack holds 8 levels and irq stays low while it is full. Eight end-of-interrupt writes empty it, and further writes to 0x38 on an empty stack have no effect.
- R12: Offset 0x34 bit 0 reads the current irq line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The bench drives random sets of one to four software-pended sources with random priorities, including repeated source numbers. Each vector read is compared with a model's max-priority, lowest-index choice, which separates priority ordering from tie-breaking. Directed sequences cover three cases:
- a level source held high against an edge source pulsed once, which tells latched pending apart from input-following;
- a nested pair, which shows that equal priority does not preempt while strictly higher priority does, and that each end-of-interrupt exposes the level beneath;
- an eight-deep nesting chain followed by extra end-of-interrupt writes, which exposes any counter that wraps on an empty stack.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int PRIO_W = 3;
    localparam int BANK_W = 32;

    localparam logic [7:0] OFS_SEL  = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_VEC  = 8'h08;
    localparam logic [7:0] OFS_IVR  = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h18;
    localparam logic [7:0] OFS_MASK = 8'h30;
    localparam logic [7:0] OFS_CORE = 8'h34;
    localparam logic [7:0] OFS_EOI  = 8'h38;
    localparam logic [7:0] OFS_SPUR = 8'h3C;
    localparam logic [7:0] OFS_EN   = 8'h40;
    localparam logic [7:0] OFS_DIS  = 8'h44;
    localparam logic [7:0] OFS_CLR  = 8'h48;
    localparam logic [7:0] OFS_SET  = 8'h4C;

    typedef struct packed {
        logic              edge_trig;
        logic [PRIO_W-1:0] prio;
    } mode_t;

    typedef struct packed {
        logic sel_w;
        logic mode_w;
        logic vec_w;
        logic ivr_rd;
        logic eoi_w;
        logic spur_w;
        logic en_c;
        logic dis_c;
        logic clr_c;
        logic set_c;
    } bus_cmd_t;

    function automatic logic [31:0] mode_word(input mode_t m);
        logic [31:0] w;
        w = '0;
        w[PRIO_W-1:0] = m.prio;
        w[4] = m.edge_trig;
        return w;
    endfunction

endpackage

// File: rtl/vic_decode.sv
module vic_decode
    import vic_pkg::*;
(
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic       wbit0,
    output bus_cmd_t   cmd
);
    logic wr_go, rd_go;

    always_comb begin
        wr_go      = bus_sel & bus_wr;
        rd_go      = bus_sel & ~bus_wr;
        cmd        = '0;
        cmd.sel_w  = wr_go & (bus_addr == OFS_SEL);
        cmd.mode_w = wr_go & (bus_addr == OFS_MODE);
        cmd.vec_w  = wr_go & (bus_addr == OFS_VEC);
        cmd.eoi_w  = wr_go & (bus_addr == OFS_EOI);
        cmd.spur_w = wr_go & (bus_addr == OFS_SPUR);
        cmd.en_c   = wr_go & wbit0 & (bus_addr == OFS_EN);
        cmd.dis_c  = wr_go & wbit0 & (bus_addr == OFS_DIS);
        cmd.clr_c  = wr_go & wbit0 & (bus_addr == OFS_CLR);
        cmd.set_c  = wr_go & wbit0 & (bus_addr == OFS_SET);
        cmd.ivr_rd = rd_go & (bus_addr == OFS_IVR);
    end
endmodule

// File: rtl/vic_src_bank.sv
module vic_src_bank
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int VEC_W   = 32,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SEL_W-1:0]         sel,
    input  mode_t                    mode_in,
    input  logic [VEC_W-1:0]         vec_in,
    input  logic                     do_mode,
    input  logic                     do_vec,
    input  logic                     do_en,
    input  logic                     do_dis,
    input  logic                     do_clr,
    input  logic                     do_set,
    input  logic [NUM_SRC-1:0]       src_in,
    input  logic                     ack,
    input  logic [SEL_W-1:0]         win_idx,
    output logic [NUM_SRC-1:0]       active,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output mode_t                    sel_mode,
    output logic [VEC_W-1:0]         sel_vec,
    output logic [VEC_W-1:0]         win_vec,
    output logic [BANK_W-1:0]        mask_bank
);
    logic [NUM_SRC-1:0] en_q, pend_q, prev_q, rise, sel_hot, ack_hot;
    mode_t              mode_q [NUM_SRC];
    logic [VEC_W-1:0]   vec_q  [NUM_SRC];

    always_comb begin
        rise = src_in & ~prev_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            sel_hot[i] = (sel == SEL_W'(i));
            ack_hot[i] = ack & (win_idx == SEL_W'(i));
            active[i]  = en_q[i] & (pend_q[i] | (~mode_q[i].edge_trig & src_in[i]));
            prio_flat[i*PRIO_W +: PRIO_W] = mode_q[i].prio;
        end
        sel_mode = mode_q[sel];
        sel_vec  = vec_q[sel];
        win_vec  = vec_q[win_idx];
        mask_bank = '0;
        for (int b = 0; b < BANK_W; b++) begin
            int idx;
            idx = (int'(sel) / BANK_W) * BANK_W + b;
            if (idx < NUM_SRC) mask_bank[b] = en_q[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            prev_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                mode_q[i] <= '0;
                vec_q[i]  <= '0;
            end
        end else begin
            prev_q <= src_in;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (sel_hot[i] && do_mode) mode_q[i] <= mode_in;
                if (sel_hot[i] && do_vec)  vec_q[i]  <= vec_in;
                if (sel_hot[i] && do_en)   en_q[i]   <= 1'b1;
                if (sel_hot[i] && do_dis)  en_q[i]   <= 1'b0;
                if (ack_hot[i])                          pend_q[i] <= 1'b0;
                if (rise[i] && mode_q[i].edge_trig)      pend_q[i] <= 1'b1;
                if (sel_hot[i] && do_set)                pend_q[i] <= 1'b1;
                if (sel_hot[i] && do_clr)                pend_q[i] <= 1'b0;
            end
        end
    end

    // R3: enable and disable commands touch no unselected source
    p_cmd_isolated_r3: assert property (@(posedge clk) disable iff (rst)
        (do_en || do_dis) |=> ((en_q & ~$past(sel_hot)) == ($past(en_q) & ~$past(sel_hot))));

    // R5: acknowledge removes the latched pending flag
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && !(rise[win_idx] && mode_q[win_idx].edge_trig)) |=> !pend_q[$past(win_idx)]);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 128,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        active,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      win_valid,
    output logic [SEL_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = SEL_W'(i);
                win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack
    import vic_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [PRIO_W-1:0] top_prio,
    output logic              empty,
    output logic              full
);
    logic [PRIO_W-1:0] stk [DEPTH];
    logic [CNT_W-1:0]  cnt;

    always_comb begin
        empty    = (cnt == '0);
        full     = (cnt == CNT_W'(DEPTH));
        top_prio = empty ? '0 : stk[IDX_W'(cnt - CNT_W'(1))];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (push && !full) begin
            stk[IDX_W'(cnt)] <= push_prio;
            cnt <= cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // R8: an accepted acknowledge adds one nesting level
    p_push_grows_r8: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R9: end-of-interrupt removes one level
    p_pop_shrinks_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !empty) |=> (cnt == $past(cnt) - CNT_W'(1)));

    // R11: end-of-interrupt on an empty stack leaves it empty
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> empty);
endmodule

// File: rtl/vic_indirect.sv
module vic_indirect
    import vic_pkg::*;
#(
    parameter int NUM_SRC    = 128,
    parameter int VEC_W      = 32,
    parameter int NEST_DEPTH = 8,
    localparam int SEL_W     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq
);
    bus_cmd_t                  cmd;
    logic [SEL_W-1:0]          sel_q, isr_q, win_idx;
    logic [VEC_W-1:0]          spur_q, sel_vec, win_vec;
    logic [NUM_SRC-1:0]        active;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [PRIO_W-1:0]         win_prio, top_prio;
    logic [BANK_W-1:0]         mask_bank;
    logic                      win_valid, st_empty, st_full, ack;
    mode_t                     sel_mode, mode_in;

    vic_decode u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wbit0   (bus_wdata[0]),
        .cmd     (cmd)
    );

    assign mode_in = '{edge_trig: bus_wdata[4], prio: bus_wdata[PRIO_W-1:0]};

    vic_src_bank #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel_q),
        .mode_in  (mode_in),
        .vec_in   (bus_wdata[VEC_W-1:0]),
        .do_mode  (cmd.mode_w),
        .do_vec   (cmd.vec_w),
        .do_en    (cmd.en_c),
        .do_dis   (cmd.dis_c),
        .do_clr   (cmd.clr_c),
        .do_set   (cmd.set_c),
        .src_in   (src_in),
        .ack      (ack),
        .win_idx  (win_idx),
        .active   (active),
        .prio_flat(prio_flat),
        .sel_mode (sel_mode),
        .sel_vec  (sel_vec),
        .win_vec  (win_vec),
        .mask_bank(mask_bank)
    );

    vic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .active   (active),
        .prio_flat(prio_flat),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    vic_nest_stack #(.DEPTH(NEST_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (ack),
        .push_prio(win_prio),
        .pop      (cmd.eoi_w),
        .top_prio (top_prio),
        .empty    (st_empty),
        .full     (st_full)
    );

    always_comb begin
        irq = win_valid & ~st_full & (st_empty | (win_prio > top_prio));
        ack = cmd.ivr_rd & irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            spur_q <= '0;
            isr_q  <= '0;
        end else begin
            if (cmd.sel_w)  sel_q  <= bus_wdata[SEL_W-1:0];
            if (cmd.spur_w) spur_q <= bus_wdata[VEC_W-1:0];
            if (cmd.ivr_rd) isr_q  <= ack ? win_idx : '0;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_SEL:  bus_rdata = 32'(sel_q);
            OFS_MODE: bus_rdata = mode_word(sel_mode);
            OFS_VEC:  bus_rdata = 32'(sel_vec);
            OFS_IVR:  bus_rdata = irq ? 32'(win_vec) : 32'(spur_q);
            OFS_STAT: bus_rdata = 32'(isr_q);
            OFS_MASK: bus_rdata = 32'(mask_bank);
            OFS_CORE: bus_rdata = {31'b0, irq};
            OFS_SPUR: bus_rdata = 32'(spur_q);
            default:  bus_rdata = '0;
        endcase
    end

    // R4: the request line is only raised for an enabled, active source
    p_irq_needs_active_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (active != '0));

    // R10: a vector read with no eligible source leaves status at zero
    p_spur_status_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd.ivr_rd && !irq) |=> (isr_q == '0));
endmodule

// File: tb/vic_indirect_test.sv
module vic_indirect_test;
    localparam int NUM = 128;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NUM-1:0]  src_in = '0;
    logic            irq;

    int total = 0;
    int bad   = 0;
    logic [31:0] rv;
    int          bprio [NUM];
    bit          bact  [NUM];

    always #4 clk = ~clk;

    vic_indirect uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic irq_is(input string req, input logic exp);
        @(negedge clk);
        chk(req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic setup(input int s, input logic [31:0] mode, input logic [31:0] vec);
        wr(8'h00, s); wr(8'h04, mode); wr(8'h08, vec); wr(8'h48, 1); wr(8'h40, 1);
    endtask

    function automatic int exp_win();
        int w = -1;
        for (int i = 0; i < NUM; i++)
            if (bact[i] && (w < 0 || bprio[i] > bprio[w])) w = i;
        return w;
    endfunction

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int srcs [4];
        int n, w;
        void'($urandom(32'd7));
        for (int i = 0; i < NUM; i++) begin bprio[i] = 0; bact[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        irq_is("R1 irq after reset", 1'b0);
        rd(8'h30, rv); chk("R1 mask bank", rv, 0);
        rd(8'h3C, rv); chk("R1 spurious reg", rv, 0);
        rd(8'h00, rv); chk("R1 select", rv, 0);
        rd(8'h10, rv); chk("R1 vector read spurious", rv, 0);
        rd(8'h18, rv); chk("R1 status", rv, 0);
        rd(8'h34, rv); chk("R1 core status", rv, 0);

        // R7 random arbitration against the bench model
        for (int t = 0; t < 24; t++) begin
            n = 1 + int'($urandom % 4);
            for (int k = 0; k < n; k++) begin
                srcs[k] = int'($urandom % NUM);
                bprio[srcs[k]] = int'($urandom % 8);
                bact[srcs[k]] = 1;
                wr(8'h00, srcs[k]);
                wr(8'h04, 32'h10 | bprio[srcs[k]]);
                wr(8'h08, 32'h1000 + srcs[k]);
                wr(8'h40, 1);
                wr(8'h4C, 1);
            end
            w = exp_win();
            rd(8'h10, rv); chk("R7 random winner vector", rv, 32'h1000 + w);
            rd(8'h18, rv); chk("R7 random winner status", rv, w);
            wr(8'h38, 0);
            for (int k = 0; k < n; k++) begin
                wr(8'h00, srcs[k]); wr(8'h44, 1); wr(8'h48, 1);
                bact[srcs[k]] = 0;
            end
            irq_is("R6 random cleanup", 1'b0);
        end

        // R2 select and per-source mode/vector
        wr(8'h00, 32'h85); rd(8'h00, rv); chk("R2 select low bits", rv, 5);
        setup(5, 32'h16, 32'h555);
        setup(6, 32'h02, 32'h666);
        wr(8'h00, 5); rd(8'h04, rv); chk("R2 mode src5", rv, 32'h16);
        rd(8'h08, rv); chk("R2 vector src5", rv, 32'h555);
        wr(8'h00, 6); rd(8'h04, rv); chk("R2 mode src6 isolated", rv, 32'h02);
        wr(8'h44, 1); wr(8'h00, 5); wr(8'h44, 1);

        // R3 enable/disable commands and bank view
        wr(8'h00, 7); wr(8'h40, 0); rd(8'h30, rv); chk("R3 bit0 clear ignored", rv, 0);
        wr(8'h40, 1); rd(8'h30, rv); chk("R3 enable src7", rv, 32'h80);
        wr(8'h00, 40); wr(8'h40, 1); rd(8'h30, rv); chk("R3 bank1 src40", rv, 32'h100);
        wr(8'h00, 7); rd(8'h30, rv); chk("R3 src7 untouched", rv, 32'h80);
        wr(8'h44, 1); rd(8'h30, rv); chk("R3 disable src7", rv, 0);
        wr(8'h00, 40); wr(8'h44, 1);

        // R4 level source
        wr(8'h00, 6); wr(8'h40, 1);
        @(negedge clk); src_in[6] = 1'b1;
        irq_is("R4 level high raises irq", 1'b1);
        rd(8'h34, rv); chk("R12 core status follows irq", rv, 1);
        wr(8'h44, 1); irq_is("R4 disabled source silent", 1'b0);
        wr(8'h40, 1); irq_is("R4 re-enabled level", 1'b1);

        // R8/R9 nesting with level src6 (prio 2) and edge src5 (prio 6)
        wr(8'h00, 5); wr(8'h40, 1);
        rd(8'h10, rv); chk("R7 level winner vector", rv, 32'h666);
        rd(8'h18, rv); chk("R7 status src6", rv, 6);
        irq_is("R8 equal priority does not nest", 1'b0);
        wr(8'h00, 5); wr(8'h4C, 1);
        irq_is("R8 higher priority nests", 1'b1);
        rd(8'h10, rv); chk("R8 nested vector", rv, 32'h555);
        wr(8'h38, 0); irq_is("R9 after one EOI level 2 on top", 1'b0);
        wr(8'h38, 0); irq_is("R9 after second EOI", 1'b1);
        rd(8'h10, rv); chk("R9 level vector again", rv, 32'h666);
        wr(8'h38, 0);
        @(negedge clk); src_in[6] = 1'b0;
        irq_is("R4 level low drops irq", 1'b0);
        rd(8'h34, rv); chk("R12 core status low", rv, 0);

        // R5 edge source
        @(negedge clk); src_in[5] = 1'b1;
        @(negedge clk); src_in[5] = 1'b0;
        irq_is("R5 edge latched", 1'b1);
        rd(8'h10, rv); chk("R5 edge vector", rv, 32'h555);
        wr(8'h38, 0); irq_is("R5 ack cleared pending", 1'b0);

        // R6 software set and clear
        wr(8'h00, 5); wr(8'h4C, 1); irq_is("R6 set makes pending", 1'b1);
        wr(8'h48, 1); irq_is("R6 clear removes pending", 1'b0);
        wr(8'h44, 1); wr(8'h00, 6); wr(8'h44, 1);

        // R7 tie goes to lowest number
        setup(10, 32'h14, 32'hAAA);
        setup(3, 32'h14, 32'h333);
        wr(8'h4C, 1); wr(8'h00, 10); wr(8'h4C, 1);
        rd(8'h10, rv); chk("R7 tie lowest index", rv, 32'h333);
        wr(8'h38, 0);
        rd(8'h10, rv); chk("R7 tie second", rv, 32'hAAA);
        rd(8'h18, rv); chk("R7 status src10", rv, 10);
        wr(8'h38, 0);
        wr(8'h44, 1); wr(8'h00, 3); wr(8'h44, 1);

        // R10 spurious
        wr(8'h3C, 32'hDEAD);
        rd(8'h10, rv); chk("R10 spurious vector", rv, 32'hDEAD);
        rd(8'h18, rv); chk("R10 spurious status", rv, 0);
        rd(8'h3C, rv); chk("R10 spurious readback", rv, 32'hDEAD);

        // R11 eight-deep nesting
        for (int k = 0; k < 8; k++) begin
            setup(20 + k, 32'h10 | k, 32'h2000 + k);
            wr(8'h4C, 1);
            rd(8'h10, rv); chk("R11 nest level vector", rv, 32'h2000 + k);
        end
        setup(28, 32'h17, 32'h2008); wr(8'h4C, 1);
        irq_is("R11 full stack holds irq low", 1'b0);
        wr(8'h38, 0); irq_is("R11 one pop reopens", 1'b1);
        rd(8'h10, rv); chk("R11 refill vector", rv, 32'h2008);
        for (int k = 0; k < 11; k++) wr(8'h38, 0);
        irq_is("R11 empty stack nothing pending", 1'b0);
        wr(8'h00, 20); wr(8'h4C, 1);
        irq_is("R11 extra EOI harmless", 1'b1);
        rd(8'h10, rv); chk("R11 lowest priority after unwind", rv, 32'h2000);
        wr(8'h38, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule